// File: doc/BRIEF.md
# DMA Channel Trigger Control

This block holds the start-side control state of a six-channel, descriptor-driven DMA engine. Software writes a global trigger word, whose low six bits ask channels to start and whose next six bits ask them to restart their descriptor chain. It also writes one control word and one start-address extension word per channel. The block remembers these requests, keeps a per-channel "chain finished" flag, and presents one request at a time to a descriptor fetch engine. Each request says which channel should fetch and whether that channel must begin at its start-address register or continue from its next-address register.

Handshake with the fetch engine:
- The fetch engine raises `req_ack` in the cycle it takes the offered request. That consumes the channel's restart request and clears its finished flag.
- Later it reports each completed descriptor on the `done_*` inputs, marking descriptors that end a chain or a frame with `done_final`.
- It reports any fetch or validation failure on the `err_*` inputs.

The trigger word can only be written. It is sticky and reads as zero. A channel's start request is withdrawn only when software rewrites that channel's control word.

Top module: `dtc_top`

## Requirements
- R1: After a synchronous reset, all trigger and restart bits are clear, every control and extension word reads 0, no request is offered, and every channel's finished flag is set, so its first request asks for the start address.
- R2: A write to address 0 ORs data bits 11:0 into the trigger word, with bit c being the start request and bit 6+c the restart request for channel c. Data bits 31:12 are ignored, and a read of address 0 returns 0.
- R3: A write to address 8+c stores data bits 29:0 as channel c's control word and clears channel c's start request. Reads of that address return the stored word with bits 31:30 at 0.
- R4: Channel c is eligible only while its start request is set, control bit 0 (enable) is 1 and control bit 1 (pause) is 0. `req_valid` is 1 exactly when some channel is eligible.
- R5: When several channels are eligible, `req_ch` names the lowest-numbered one.
- R6: While a request is offered, `req_use_start` is 1 if the granted channel's finished flag or restart request is set, and 0 otherwise. It is 0 when no request is offered.
- R7: On a cycle with `req_ack` while a request is offered, the granted channel's restart request and finished flag clear, and its start request stays set.
- R8: `err_valid` for channel c, or `done_valid` with `done_final` for channel c, sets channel c's finished flag. `done_valid` without `done_final` leaves the flag unchanged.
- R9: A write to address 16+c stores only data bits 15:0 as channel c's start-address extension. `req_start_ext` shows the granted channel's extension.
- R10: When an acknowledge falls in the same cycle as a new restart write or a final completion for the same channel, the set wins over the clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 5 | Write address: 0 trigger word, 8+c control, 16+c extension |
| wr_data | input | 32 | Write data |
| rd_addr | input | 5 | Read address, same map |
| rd_data | output | 32 | Read data (combinational) |
| req_valid | output | 1 | A channel is eligible to fetch |
| req_ch | output | 3 | Granted channel |
| req_use_start | output | 1 | 1: fetch from start address; 0: from next address |
| req_start_ext | output | 16 | Start-address extension of the granted channel |
| req_ack | input | 1 | Fetch engine takes the offered request |
| done_valid | input | 1 | A descriptor completed |
| done_ch | input | 3 | Channel of the completed descriptor |
| done_final | input | 1 | Completed descriptor ends a chain or frame |
| err_valid | input | 1 | Fetch or validation error |
| err_ch | input | 3 | Channel of the error |

## Verification
The bench targets the quiet ways a channel gets stuck or runs away:
- A control rewrite must cancel a pending start. Without that, a channel would launch the moment it is enabled.
- A paused channel must stay silent even while triggered.
- A consumed restart must not re-select the start address on the following fetch, or the chain would loop on its first descriptor.
- A non-final completion must not mark the chain finished.
- Same-cycle collisions between an acknowledge and a fresh restart, or a final completion, must not lose the set. A design that let the clear win would resume from a stale next address.

Fixed priority is checked with two channels eligible at once. The masking of high data bits is checked on every register kind.

// File: rtl/dtc_pkg.sv
package dtc_pkg;
    localparam int NUM_CH    = 6;
    localparam int CH_W      = $clog2(NUM_CH);
    localparam int DATA_W    = 32;
    localparam int ADDR_W    = 5;
    localparam int CTRL_KEEP = 30;
    localparam int EXT_KEEP  = 16;
    localparam int TRIG_W    = 2 * NUM_CH;
    localparam int TRIG_ADDR = 0;
    localparam int CTRL_BASE = 8;
    localparam int EXT_BASE  = 16;

    // Trigger word: restart requests above start requests.
    typedef struct packed {
        logic [NUM_CH-1:0] restart;
        logic [NUM_CH-1:0] start;
    } trig_word_t;

    typedef struct packed {
        logic [CTRL_KEEP-3:0] spare;
        logic                 pause;
        logic                 enable;
    } chan_ctrl_t;

    function automatic logic [ADDR_W-1:0] ctrl_addr(input int c);
        return ADDR_W'(CTRL_BASE + c);
    endfunction

    function automatic logic [ADDR_W-1:0] ext_addr(input int c);
        return ADDR_W'(EXT_BASE + c);
    endfunction
endpackage

// File: rtl/dtc_trig_reg.sv
module dtc_trig_reg
    import dtc_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              glob_wr,
    input  logic [TRIG_W-1:0] glob_data,
    input  logic [NUM_CH-1:0] ctrl_wr,
    input  logic [NUM_CH-1:0] consume,
    output trig_word_t        trig_q
);
    trig_word_t set_w;
    trig_word_t trig_d;

    always_comb begin
        set_w          = glob_wr ? trig_word_t'(glob_data) : '0;
        trig_d.start   = (trig_q.start & ~ctrl_wr) | set_w.start;
        trig_d.restart = (trig_q.restart & ~consume) | set_w.restart;
    end

    always_ff @(posedge clk) begin
        if (rst) trig_q <= '0;
        else     trig_q <= trig_d;
    end

    for (genvar i = 0; i < NUM_CH; i++) begin : g_chk
        assert_start_sticky_R2: assert property (@(posedge clk) disable iff (rst)
            trig_q.start[i] && !ctrl_wr[i] |=> trig_q.start[i]);
        assert_ctrl_cancels_R3: assert property (@(posedge clk) disable iff (rst)
            ctrl_wr[i] && !(glob_wr && glob_data[i]) |=> !trig_q.start[i]);
        assert_restart_consumed_R7: assert property (@(posedge clk) disable iff (rst)
            consume[i] && !(glob_wr && glob_data[NUM_CH+i]) |=> !trig_q.restart[i]);
        assert_restart_set_wins_R10: assert property (@(posedge clk) disable iff (rst)
            glob_wr && glob_data[NUM_CH+i] |=> trig_q.restart[i]);
    end
endmodule

// File: rtl/dtc_chan_ctrl.sv
module dtc_chan_ctrl
    import dtc_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 ctrl_wr,
    input  logic                 ext_wr,
    input  logic [CTRL_KEEP-1:0] ctrl_data,
    input  logic [EXT_KEEP-1:0]  ext_data,
    input  logic                 consume,
    input  logic                 finish_set,
    output chan_ctrl_t           ctrl_q,
    output logic [EXT_KEEP-1:0]  ext_q,
    output logic                 finished_q
);
    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl_q     <= '0;
            ext_q      <= '0;
            finished_q <= 1'b1;
        end else begin
            if (ctrl_wr) ctrl_q <= chan_ctrl_t'(ctrl_data);
            if (ext_wr)  ext_q  <= ext_data;
            // completion or error set has priority over the acknowledge clear
            if (finish_set)   finished_q <= 1'b1;
            else if (consume) finished_q <= 1'b0;
        end
    end

    assert_finish_sets_R8: assert property (@(posedge clk) disable iff (rst)
        finish_set |=> finished_q);
    assert_ack_clears_R7: assert property (@(posedge clk) disable iff (rst)
        consume && !finish_set |=> !finished_q);
    assert_flag_holds_R8: assert property (@(posedge clk) disable iff (rst)
        !consume && !finish_set |=> finished_q == $past(finished_q));
endmodule

// File: rtl/dtc_prio_arb.sv
module dtc_prio_arb
    import dtc_pkg::*;
(
    input  logic [NUM_CH-1:0] eligible,
    output logic              grant_valid,
    output logic [CH_W-1:0]   grant_idx
);
    always_comb begin
        grant_idx = '0;
        for (int i = NUM_CH - 1; i >= 0; i--) begin
            if (eligible[i]) grant_idx = CH_W'(i);
        end
        grant_valid = |eligible;
    end
endmodule

// File: rtl/dtc_top.sv
module dtc_top
    import dtc_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [DATA_W-1:0] rd_data,
    output logic              req_valid,
    output logic [CH_W-1:0]   req_ch,
    output logic              req_use_start,
    output logic [EXT_KEEP-1:0] req_start_ext,
    input  logic              req_ack,
    input  logic              done_valid,
    input  logic [CH_W-1:0]   done_ch,
    input  logic              done_final,
    input  logic              err_valid,
    input  logic [CH_W-1:0]   err_ch
);
    trig_word_t          trig_q;
    chan_ctrl_t          ctrl_q   [NUM_CH];
    logic [EXT_KEEP-1:0] ext_q    [NUM_CH];
    logic [NUM_CH-1:0]   finished_q;
    logic [NUM_CH-1:0]   ctrl_wr, ext_wr, consume, finish_set, eligible;
    logic                glob_wr;
    logic                unused_hi_bits;

    assign unused_hi_bits = ^wr_data[DATA_W-1:CTRL_KEEP];
    assign glob_wr        = wr_en && (wr_addr == ADDR_W'(TRIG_ADDR));

    for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
        assign ctrl_wr[c]    = wr_en && (wr_addr == ctrl_addr(c));
        assign ext_wr[c]     = wr_en && (wr_addr == ext_addr(c));
        assign consume[c]    = req_ack && req_valid && (req_ch == CH_W'(c));
        assign finish_set[c] = (done_valid && done_final && (done_ch == CH_W'(c)))
                             || (err_valid && (err_ch == CH_W'(c)));
        assign eligible[c]   = trig_q.start[c] && ctrl_q[c].enable && !ctrl_q[c].pause;

        dtc_chan_ctrl u_chan (
            .clk        (clk),
            .rst        (rst),
            .ctrl_wr    (ctrl_wr[c]),
            .ext_wr     (ext_wr[c]),
            .ctrl_data  (wr_data[CTRL_KEEP-1:0]),
            .ext_data   (wr_data[EXT_KEEP-1:0]),
            .consume    (consume[c]),
            .finish_set (finish_set[c]),
            .ctrl_q     (ctrl_q[c]),
            .ext_q      (ext_q[c]),
            .finished_q (finished_q[c])
        );

        assert_lowest_wins_R5: assert property (@(posedge clk) disable iff (rst)
            eligible[c] |-> req_valid && (req_ch <= CH_W'(c)));
    end

    dtc_trig_reg u_trig (
        .clk       (clk),
        .rst       (rst),
        .glob_wr   (glob_wr),
        .glob_data (wr_data[TRIG_W-1:0]),
        .ctrl_wr   (ctrl_wr),
        .consume   (consume),
        .trig_q    (trig_q)
    );

    dtc_prio_arb u_arb (
        .eligible    (eligible),
        .grant_valid (req_valid),
        .grant_idx   (req_ch)
    );

    assign req_use_start = req_valid && (finished_q[req_ch] || trig_q.restart[req_ch]);
    assign req_start_ext = ext_q[req_ch];

    always_comb begin
        rd_data = '0;
        for (int c = 0; c < NUM_CH; c++) begin
            if (rd_addr == ctrl_addr(c)) rd_data = DATA_W'(ctrl_q[c]);
            if (rd_addr == ext_addr(c))  rd_data = DATA_W'(ext_q[c]);
        end
    end

    assert_grant_gated_R4: assert property (@(posedge clk) disable iff (rst)
        req_valid |-> trig_q.start[req_ch] && ctrl_q[req_ch].enable && !ctrl_q[req_ch].pause);
    assert_idle_no_start_R6: assert property (@(posedge clk) disable iff (rst)
        !req_valid |-> !req_use_start);
    assert_ack_keeps_start_R7: assert property (@(posedge clk) disable iff (rst)
        consume[req_ch] && !ctrl_wr[req_ch] |=> trig_q.start[$past(req_ch)]);
endmodule

// File: tb/dtc_top_tb_top.sv
module dtc_top_tb_top;
    localparam logic [1:0] OP_WR = 2'd0, OP_ACK = 2'd1, OP_DONE = 2'd2, OP_ERR = 2'd3;

    typedef struct packed {
        logic [1:0]  op;
        logic [4:0]  addr;
        logic [31:0] data;
        logic        ev;
        logic [2:0]  ech;
        logic        es;
    } vec_t;

    localparam int NV = 19;
    localparam vec_t VECS [NV] = '{
        '{OP_WR,   5'd0, 32'h1,        1'b0, 3'd0, 1'b0}, // R4 triggered, not enabled
        '{OP_WR,   5'd8, 32'h1,        1'b0, 3'd0, 1'b0}, // R3 control write cancels trigger
        '{OP_WR,   5'd0, 32'h1,        1'b1, 3'd0, 1'b1}, // R4 R1 first request uses start
        '{OP_WR,   5'd8, 32'h3,        1'b0, 3'd0, 1'b0}, // R3 paused, trigger cancelled
        '{OP_WR,   5'd0, 32'h1,        1'b0, 3'd0, 1'b0}, // R4 paused blocks
        '{OP_WR,   5'd8, 32'h1,        1'b0, 3'd0, 1'b0}, // R3
        '{OP_WR,   5'd0, 32'h1,        1'b1, 3'd0, 1'b1}, // R6
        '{OP_ACK,  5'd0, 32'h0,        1'b1, 3'd0, 1'b0}, // R7 finished clears, start stays
        '{OP_WR,   5'd0, 32'h40,       1'b1, 3'd0, 1'b1}, // R6 R2 restart request
        '{OP_ACK,  5'd0, 32'h0,        1'b1, 3'd0, 1'b0}, // R7 restart consumed
        '{OP_DONE, 5'd0, 32'h0,        1'b1, 3'd0, 1'b0}, // R8 non-final done
        '{OP_DONE, 5'd0, 32'h1,        1'b1, 3'd0, 1'b1}, // R8 final done
        '{OP_ACK,  5'd0, 32'h0,        1'b1, 3'd0, 1'b0}, // R7
        '{OP_ERR,  5'd0, 32'h0,        1'b1, 3'd0, 1'b1}, // R8 error
        '{OP_ACK,  5'd0, 32'h0,        1'b1, 3'd0, 1'b0}, // R7
        '{OP_WR,   5'd10, 32'h1,       1'b1, 3'd0, 1'b0}, // R5 enable ch2
        '{OP_WR,   5'd0, 32'h4,        1'b1, 3'd0, 1'b0}, // R5 ch0 wins over ch2
        '{OP_WR,   5'd8, 32'h0,        1'b1, 3'd2, 1'b1}, // R5 R3 ch2 takes over
        '{OP_WR,   5'd0, 32'hFFFFF000, 1'b1, 3'd2, 1'b1}  // R2 high bits ignored
    };

    logic        clk = 1'b0;
    logic        rst;
    logic        wr_en, req_ack, done_valid, done_final, err_valid;
    logic [4:0]  wr_addr, rd_addr;
    logic [31:0] wr_data, rd_data;
    logic        req_valid, req_use_start;
    logic [2:0]  req_ch, done_ch, err_ch;
    logic [15:0] req_start_ext;
    int          n_run = 0, n_fail = 0;
    bit          finished_run = 1'b0;

    always #10 clk = ~clk;

    dtc_top dut_i (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .rd_addr(rd_addr), .rd_data(rd_data), .req_valid(req_valid), .req_ch(req_ch),
        .req_use_start(req_use_start), .req_start_ext(req_start_ext), .req_ack(req_ack),
        .done_valid(done_valid), .done_ch(done_ch), .done_final(done_final),
        .err_valid(err_valid), .err_ch(err_ch)
    );

    task automatic clear_in();
        wr_en = 0; wr_addr = '0; wr_data = '0; req_ack = 0;
        done_valid = 0; done_ch = '0; done_final = 0; err_valid = 0; err_ch = '0;
    endtask

    // Inputs are set before the call on a negedge; one posedge applies them.
    task automatic tick();
        @(posedge clk); #1;
        clear_in();
    endtask

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic chk_req(input string req, input logic ev, input logic [2:0] ech, input logic es);
        chk({req, " req_valid"}, 32'(req_valid), 32'(ev));
        chk({req, " req_use_start"}, 32'(req_use_start), 32'(es));
        if (ev) chk({req, " req_ch"}, 32'(req_ch), 32'(ech));
    endtask

    task automatic rd_chk(input string req, input logic [4:0] a, input logic [31:0] exp);
        rd_addr = a; #1;
        chk(req, rd_data, exp);
    endtask

    initial begin
        #(20 * 150000);
        if (!finished_run) begin
            n_run++; n_fail++;
            $display("FAIL watchdog actual=timeout expected=completion");
            $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin
        clear_in(); rd_addr = '0; rst = 1;
        repeat (3) @(posedge clk);
        @(negedge clk); rst = 0; #1;
        // R1 reset state
        chk_req("R1", 1'b0, 3'd0, 1'b0);
        rd_chk("R1 ctrl0", 5'd8, 32'h0);
        rd_chk("R1 ext0", 5'd16, 32'h0);

        for (int i = 0; i < NV; i++) begin
            @(negedge clk);
            case (VECS[i].op)
                OP_WR:   begin wr_en = 1; wr_addr = VECS[i].addr; wr_data = VECS[i].data; end
                OP_ACK:  req_ack = 1;
                OP_DONE: begin done_valid = 1; done_ch = VECS[i].addr[2:0]; done_final = VECS[i].data[0]; end
                default: begin err_valid = 1; err_ch = VECS[i].addr[2:0]; end
            endcase
            tick();
            chk_req($sformatf("vec%0d R4/R5/R6/R7/R8", i), VECS[i].ev, VECS[i].ech, VECS[i].es);
        end

        // R2 trigger word reads as zero
        rd_chk("R2 read trigger", 5'd0, 32'h0);
        rd_chk("R3 ctrl2 readback", 5'd10, 32'h1);
        // R3 top bits dropped
        @(negedge clk); wr_en = 1; wr_addr = 5'd11; wr_data = 32'hFFFFFFFC; tick();
        rd_chk("R3 ctrl3 mask", 5'd11, 32'h3FFFFFFC);
        // R9 extension keeps 16 bits, shown for granted ch2
        @(negedge clk); wr_en = 1; wr_addr = 5'd18; wr_data = 32'hABCD1234; tick();
        rd_chk("R9 ext2 mask", 5'd18, 32'h00001234);
        chk("R9 req_start_ext", 32'(req_start_ext), 32'h1234);

        // R10 ack collides with a restart write for ch2 (bit 8)
        @(negedge clk); req_ack = 1; wr_en = 1; wr_addr = 5'd0; wr_data = 32'h100; tick();
        chk_req("R10 restart vs ack", 1'b1, 3'd2, 1'b1);
        @(negedge clk); req_ack = 1; tick();
        chk_req("R7 ch2 consumed", 1'b1, 3'd2, 1'b0);
        // R10 ack collides with a final completion for ch2
        @(negedge clk); req_ack = 1; done_valid = 1; done_ch = 3'd2; done_final = 1; tick();
        chk_req("R10 final vs ack", 1'b1, 3'd2, 1'b1);
        // R8 error on another channel leaves ch2 alone
        @(negedge clk); req_ack = 1; tick();
        @(negedge clk); err_valid = 1; err_ch = 3'd4; tick();
        chk_req("R8 other channel", 1'b1, 3'd2, 1'b0);

        // R1 reset mid-run restores finished flags and clears state
        @(negedge clk); rst = 1; @(negedge clk); rst = 0; #1;
        chk_req("R1 after reset", 1'b0, 3'd0, 1'b0);
        rd_chk("R1 ctrl2 cleared", 5'd10, 32'h0);
        @(negedge clk); wr_en = 1; wr_addr = 5'd13; wr_data = 32'h1; tick();
        @(negedge clk); wr_en = 1; wr_addr = 5'd0; wr_data = 32'h20; tick();
        chk_req("R1 ch5 start address", 1'b1, 3'd5, 1'b1);

        finished_run = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule